// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five software contexts ("localities", numbered 0 to 4) currently owns a shared trusted-module register interface. Every locality sees its own 4 KB window of the register space. At offset zero of each window sits a one-byte ownership register. Through it, software asks for the interface, confirms that it holds it, and hands it back.

The arbiter keeps one waiting flag per locality and at most one owner. While nobody owns the interface, it promotes the highest-numbered waiting locality to owner on the next clock. The owner's register shows whether anyone else is queued, so the owner can tell that it should yield. Every change of owner, gained or lost, produces a one-cycle event pulse for the interrupt logic.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. The port has no back-pressure. Nothing in the block responds until the start-up input reports that initialisation and self-test are complete.

Top module: `loc_access_arbiter`

## Requirements
- R1: The locality is address bits [14:12] and the ownership register is at offset 0x000 of the window. Bit 15 must be 0. Any other offset, a locality field of 5 to 7, or bit 15 set: reads give 0x00 and writes change nothing.
- R2: Until `init_done` has been sampled high at a clock edge, every register reads 0x00 and every write is ignored. From that edge on, bit 7 (valid) reads 1 in all five ownership registers, and it stays 1 until reset.
- R3: A write with bit 1 set (and bit 5 clear) from a locality that is not the owner marks that locality as waiting. Bit 1 of that locality's register reads 1 while it waits.
- R4: On a clock edge where there is no owner and at least one locality waits, the highest-numbered waiting locality becomes owner and its waiting flag clears.
- R5: The owner's register reads bit 5 (active) = 1 together with bit 7. Every other register reads bit 5 = 0. `owner_valid` and `owner_id` show the owner.
- R6: A write with bit 5 set from the owner releases ownership at that edge. At least one cycle without an owner follows before the next grant.
- R7: A write with bit 5 set from a locality that is not the owner clears only that locality's waiting flag. The owner is unchanged.
- R8: Bit 2 (pending) reads 1 in the owner's register whenever some other locality waits. It reads 0 in every register that is not the owner's.
- R9: `loc_chg_evt` is high for exactly the one cycle after each edge at which ownership is granted or released, and at no other time.
- R10: When bits 5 and 1 are written together, bit 5 decides and the request is dropped. A bit-1 write from the current owner has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Start-up complete; sets the sticky valid state |
| bus_addr | input | 16 | Register address: offset OR (locality << 12) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Owning locality, meaningful when `owner_valid` is high |
| loc_chg_evt | output | 1 | One-cycle pulse after each ownership change |

## Verification
The assertions check the following on every cycle:
- the owner never also carries a waiting flag;
- a free interface with a waiting locality is always granted on the next edge;
- an owner that does not release keeps the same id;
- a release always empties the owner slot;
- the event pulse coincides exactly with the owner slot filling or emptying;
- nothing is held before valid.

Other behaviour can only be shown by the bench's scenarios against its reference model: the address decode of foreign offsets and localities, which locality wins when several wait, the exact byte read back in each window, and the precedence of bit 5 over bit 1.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // Bit positions inside the per-locality ownership byte; software decodes these.
  localparam int unsigned BIT_VALID  = 7;
  localparam int unsigned BIT_ACTIVE = 5;
  localparam int unsigned BIT_PEND   = 2;
  localparam int unsigned BIT_REQ    = 1;

  // Decoded write command to an ownership register.
  typedef struct packed {
    logic req;   // bit 1 written as 1
    logic drop;  // bit 5 written as 1
  } own_cmd_t;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOC_SHIFT = 12,
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned LOC_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LOC_W-1:0]  loc
);
  localparam int unsigned HI_LSB = LOC_SHIFT + LOC_W;

  logic off_zero;
  logic hi_zero;
  logic in_range;

  assign loc      = addr[LOC_SHIFT +: LOC_W];
  assign off_zero = (addr[LOC_SHIFT-1:0] == '0);
  assign hi_zero  = ((addr >> HI_LSB) == '0);
  assign in_range = ({1'b0, loc} < (LOC_W+1)'(NUM_LOC));
  assign hit      = off_zero && hi_zero && in_range;
endmodule

// File: rtl/loc_req_bank.sv
module loc_req_bank
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] wr_hit_vec,
  input  own_cmd_t           cmd,
  input  logic               owner_vld,
  input  logic [LOC_W-1:0]   owner_id,
  input  logic [NUM_LOC-1:0] grant_vec,
  output logic [NUM_LOC-1:0] pending
);
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_slot
    logic is_owner;
    logic set_req;
    logic clr_req;

    assign is_owner = owner_vld && (owner_id == LOC_W'(g));
    assign set_req  = wr_hit_vec[g] && cmd.req && !cmd.drop && !is_owner;
    assign clr_req  = (wr_hit_vec[g] && cmd.drop && !is_owner) || grant_vec[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pending[g] <= 1'b0;
      else if (clr_req) pending[g] <= 1'b0;
      else if (set_req) pending[g] <= 1'b1;
    end
  end

  // R4: the owning locality never carries a waiting flag
  p_owner_not_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
    owner_vld |-> !pending[owner_id]);
endmodule

// File: rtl/loc_grant.sv
module loc_grant #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] pending,
  input  logic               release_req,
  output logic               owner_vld,
  output logic [LOC_W-1:0]   owner_id,
  output logic [NUM_LOC-1:0] grant_vec,
  output logic               loc_chg_evt
);
  logic [LOC_W-1:0] pick_id;
  logic             any_wait;
  logic             do_grant;

  // Highest-numbered waiter wins: later iterations override earlier ones.
  always_comb begin
    pick_id = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (pending[i]) pick_id = LOC_W'(i);
  end

  assign any_wait  = |pending;
  assign do_grant  = !owner_vld && any_wait;
  assign grant_vec = do_grant ? (NUM_LOC'(1) << pick_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_vld   <= 1'b0;
      owner_id    <= '0;
      loc_chg_evt <= 1'b0;
    end else begin
      loc_chg_evt <= 1'b0;
      if (owner_vld && release_req) begin
        owner_vld   <= 1'b0;
        loc_chg_evt <= 1'b1;
      end else if (do_grant) begin
        owner_vld   <= 1'b1;
        owner_id    <= pick_id;
        loc_chg_evt <= 1'b1;
      end
    end
  end

  // R4: a free interface with a waiter is granted at the next edge
  p_free_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_vld && any_wait) |=> owner_vld);
  // R6: release empties the slot
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && release_req) |=> !owner_vld);
  // R6: an owner that does not release keeps its id
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && !release_req) |=> (owner_vld && $stable(owner_id)));
  // R9: the pulse matches an ownership change exactly
  p_evt_follows_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_chg_evt |-> ($rose(owner_vld) || $fell(owner_vld)));
  p_change_has_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(owner_vld) || $fell(owner_vld)) |-> loc_chg_evt);
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOC_SHIFT = 12,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              owner_valid,
  output logic [2:0]        owner_id,
  output logic              loc_chg_evt
);
  localparam int unsigned LOC_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;

  logic               valid_q;
  logic               acc_hit;
  logic [LOC_W-1:0]   acc_loc;
  logic [NUM_LOC-1:0] wr_hit_vec;
  logic [NUM_LOC-1:0] pending;
  logic [NUM_LOC-1:0] grant_vec;
  logic               own_vld;
  logic [LOC_W-1:0]   own_id;
  logic               release_req;
  logic               sel_owner;
  logic               others_wait;
  own_cmd_t           cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_q | init_done;
  end

  loc_addr_decode #(
    .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .NUM_LOC(NUM_LOC), .LOC_W(LOC_W)
  ) u_dec (
    .addr(bus_addr), .hit(acc_hit), .loc(acc_loc)
  );

  assign cmd.req  = bus_wdata[BIT_REQ];
  assign cmd.drop = bus_wdata[BIT_ACTIVE];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_hit
    assign wr_hit_vec[g] = valid_q && bus_wr && acc_hit && (acc_loc == LOC_W'(g));
  end

  assign sel_owner   = own_vld && (own_id == acc_loc);
  assign release_req = |wr_hit_vec && cmd.drop && sel_owner;

  loc_req_bank #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_hit_vec(wr_hit_vec), .cmd(cmd),
    .owner_vld(own_vld), .owner_id(own_id), .grant_vec(grant_vec),
    .pending(pending)
  );

  loc_grant #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_grant (
    .clk(clk), .rst_n(rst_n), .pending(pending), .release_req(release_req),
    .owner_vld(own_vld), .owner_id(own_id), .grant_vec(grant_vec),
    .loc_chg_evt(loc_chg_evt)
  );

  assign others_wait = |(pending & ~(NUM_LOC'(1) << acc_loc));

  always_comb begin
    bus_rdata = '0;
    if (valid_q && acc_hit) begin
      bus_rdata[BIT_VALID]  = 1'b1;
      bus_rdata[BIT_ACTIVE] = sel_owner;
      bus_rdata[BIT_PEND]   = sel_owner && others_wait;
      bus_rdata[BIT_REQ]    = pending[acc_loc];
    end
  end

  assign owner_valid = own_vld;
  assign owner_id    = 3'(own_id);

  // R2: nothing is held before start-up completes
  p_quiet_until_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (!own_vld && (pending == '0)));
  // R2: valid never drops once set
  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
endmodule

// File: tb/test_loc_access_arbiter.sv
module test_loc_access_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        owner_valid;
  logic [2:0]  owner_id;
  logic        loc_chg_evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit run_cmp = 1'b0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  loc_access_arbiter i_loc_access_arbiter (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .owner_valid(owner_valid), .owner_id(owner_id), .loc_chg_evt(loc_chg_evt)
  );

  // Behavioural reference model
  bit m_valid;
  bit m_pend[5];
  int m_own;
  bit m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_own = -1; m_evt = 0;
      foreach (m_pend[i]) m_pend[i] = 0;
    end else begin
      bit np[5];
      int no;
      int loc;
      np = m_pend; no = m_own;
      loc = (bus_addr >> 12) & 7;
      if (m_valid && bus_wr && bus_addr[15] == 0 && loc < 5 && bus_addr[11:0] == 0) begin
        if (bus_wdata[5]) begin
          if (m_own == loc) no = -1; else np[loc] = 0;
        end else if (bus_wdata[1] && m_own != loc) np[loc] = 1;
      end
      if (m_own == -1) begin
        for (int i = 4; i >= 0; i--)
          if (m_pend[i]) begin no = i; np[i] = 0; break; end
      end
      m_evt = (no != m_own);
      m_own = no; m_pend = np;
      m_valid = m_valid | init_done;
    end
  end

  function automatic int exp_rd(logic [15:0] a);
    int loc;
    int v;
    bit oth;
    loc = (a >> 12) & 7;
    if (!m_valid || a[15] || loc > 4 || a[11:0] != 0) return 0;
    v = 8'h80;
    oth = 0;
    for (int i = 0; i < 5; i++) if (i != loc && m_pend[i]) oth = 1;
    if (m_own == loc) v |= 8'h20;
    if (m_own == loc && oth) v |= 8'h04;
    if (m_pend[loc]) v |= 8'h02;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R1 rdata", bus_rdata, exp_rd(bus_addr));
      chk("R5 owner_valid", owner_valid, (m_own >= 0));
      if (m_own >= 0) chk("R5 owner_id", owner_id, m_own);
      chk("R9 loc_chg_evt", loc_chg_evt, m_evt);
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, int exp, string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset rdata", bus_rdata, 0);
    chk("R5 reset owner", owner_valid, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(posedge clk); #1;
    // R2: writes before start-up are ignored
    wr(16'h0000, 8'h02);
    rd(16'h0000, 8'h00, "R2 before valid");
    init_done = 1'b1;
    rd(16'h0000, 8'h00, "R2 edge not yet seen");
    init_done = 1'b0;
    rd(16'h0000, 8'h80, "R2 valid sticky");
    // R3 then grant
    wr(16'h1000, 8'h02);
    rd(16'h1000, 8'h82, "R3 waiting bit");
    chk("R9 grant pulse", loc_chg_evt, 1);
    rd(16'h1000, 8'hA0, "R5 owner reads active");
    chk("R5 owner_id", owner_id, 1);
    // R8: others wait
    wr(16'h3000, 8'h02);
    wr(16'h0000, 8'h02);
    rd(16'h1000, 8'hA4, "R8 owner sees waiter");
    rd(16'h3000, 8'h82, "R8 non-owner no pending bit");
    // R6 release, R4 highest wins
    wr(16'h1000, 8'h20);
    chk("R6 released", owner_valid, 0);
    chk("R9 release pulse", loc_chg_evt, 1);
    rd(16'h1000, 8'h80, "R6 released reads");
    rd(16'h3000, 8'hA4, "R4 highest granted");
    rd(16'h0000, 8'h82, "R4 lower still waits");
    // R7
    wr(16'h0000, 8'h20);
    rd(16'h0000, 8'h80, "R7 withdraw");
    rd(16'h3000, 8'hA0, "R7 owner unchanged");
    chk("R7 owner_id", owner_id, 3);
    // R10
    wr(16'h3000, 8'h02);
    rd(16'h3000, 8'hA0, "R10 owner request ignored");
    wr(16'h2000, 8'h22);
    rd(16'h2000, 8'h80, "R10 bit5 wins");
    // R1 decode
    wr(16'h4018, 8'h02);
    rd(16'h4000, 8'h80, "R1 other offset ignored");
    wr(16'h5000, 8'h02);
    rd(16'h5000, 8'h00, "R1 locality 5 reads zero");
    wr(16'h8000, 8'h02);
    rd(16'h0000, 8'h80, "R1 bit15 ignored");
    rd(16'h4018, 8'h00, "R1 other offset reads zero");
    wr(16'h4000, 8'h02);
    rd(16'h4000, 8'h82, "R1 locality 4 window");
    rd(16'h3000, 8'hA4, "R8 owner sees locality 4");
    wr(16'h3000, 8'h20);
    rd(16'h3000, 8'h80, "R6 idle cycle");
    chk("R4 owner_id 4", owner_id, 4);
    // Mixed traffic, model compared every cycle
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [15:0] a;
      logic [7:0] d;
      sel = $urandom_range(0, 9);
      a = 16'($urandom_range(0, 7) << 12) | ((sel == 9) ? 16'h0018 : 16'h0000);
      case ($urandom_range(0, 3))
        0: d = 8'h02;
        1: d = 8'h20;
        2: d = 8'h22;
        default: d = 8'h00;
      endcase
      if (sel < 6) wr(a, d);
      else begin bus_addr = a; @(posedge clk); #1; end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule